// File: doc/BRIEF.md
# Wheel Revolution to Distance Pulse Divider

This block turns a stream of wheel-revolution pulses into distance pulses. Each distance pulse stands for roughly one hundred metres of travel, whatever the tyre size. A 2-bit size code picks one of four tyre diameters. The block turns that code into a divide ratio with a small arithmetic lookup. A counter then emits one single-cycle strobe for every N revolutions it counts.

The wheel input must already be synchronised to the system clock. The block counts its rising edges only, so a wheel level held high for several clocks counts once.

The ratio is captured in three situations: at reset, at clear, and at the reload that follows each strobe. A size code changed in the middle of a division therefore never splits one division between two ratios. An active-high clear input empties the count and restarts a division, for example when a new fare starts.

Top module: `wheel_dist_div`

## Requirements
- R1: After synchronous reset, `dist_pulse` is low and the revolution count is zero, so the first strobe needs a full N revolutions.
- R2: Size code 0 (520 mm) divides by 61, code 1 (540 mm) by 59, code 2 (560 mm) by 57, and code 3 (580 mm) by 55. The ratio is 61 minus twice the code.
- R3: `dist_pulse` goes high for exactly one clock, in the cycle after the clock edge that samples the N-th counted rising edge. Counting then restarts from zero, so strobes repeat every N revolutions.
- R4: Only a low-to-high transition of `wheel_in` between two clock samples counts. A level held high for many cycles counts as one revolution.
- R5: While `clr` is high, the count is held at zero and no revolution is counted. After `clr` is released, the next strobe comes on the N-th revolution.
- R6: A new `size_sel` value given in the middle of a division does not affect the current division. It takes effect at the reload after the next strobe, or at once when `clr` is asserted.
- R7: When `clr` is high in the same cycle as the N-th rising edge, `clr` wins. No strobe is produced, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Active-high start/clear of the divider |
| wheel_in | input | 1 | Synchronised wheel revolution signal |
| size_sel | input | 2 | Tyre size code selecting the divide ratio |
| dist_pulse | output | 1 | One-cycle strobe per N revolutions |

## Verification
Two events can fall in the same cycle: a clear and the terminal revolution that would reload the counter and fire a strobe. The bench counts a divider up to N-1 revolutions. It then raises `wheel_in` and `clr` at the same falling edge. It expects no strobe in the following cycle, and it expects the next strobe only after N fresh revolutions. A related case changes the size code in the middle of a division. The bench checks that the old ratio finishes the current division and that the new ratio governs the division that follows.

// File: rtl/wheel_div_pkg.sv
package wheel_div_pkg;

    // Default lookup: ratio = BASE - STEP * code
    localparam int DEF_SEL_W      = 2;
    localparam int DEF_BASE_RATIO = 61;
    localparam int DEF_RATIO_STEP = 2;

    // Per-cycle events presented to the division counter
    typedef struct packed {
        logic rise;   // one counted revolution
        logic clear;  // restart the division
    } div_evt_t;

    function automatic int ratio_for(input int code, input int base, input int step);
        return base - step * code;
    endfunction

endpackage

// File: rtl/wdiv_edge.sv
module wdiv_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise_out
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level_in;
    end

    assign rise_out = level_in & ~level_q;

    // R4: a counted edge can never be followed by another in the next cycle
    a_r4_single_edge: assert property (@(posedge clk) disable iff (rst)
        rise_out |=> !rise_out);

endmodule

// File: rtl/wdiv_ratio.sv
module wdiv_ratio #(
    parameter int SEL_W      = wheel_div_pkg::DEF_SEL_W,
    parameter int BASE_RATIO = wheel_div_pkg::DEF_BASE_RATIO,
    parameter int RATIO_STEP = wheel_div_pkg::DEF_RATIO_STEP,
    parameter int CNT_W      = $clog2(BASE_RATIO + 1)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] ratio
);
    localparam int NUM_SIZES = 1 << SEL_W;

    logic [CNT_W-1:0] table_w [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        assign table_w[g] = CNT_W'(wheel_div_pkg::ratio_for(g, BASE_RATIO, RATIO_STEP));
    end

    assign ratio = table_w[sel];

endmodule

// File: rtl/wdiv_count.sv
module wdiv_count #(
    parameter int CNT_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wheel_div_pkg::div_evt_t evt,
    input  logic [CNT_W-1:0]      ratio_in,
    output logic                  strobe
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] ratio_q;
    logic             last_w;

    assign last_w = (count_q == ratio_q - ONE);

    always_ff @(posedge clk) begin
        if (rst || evt.clear) begin
            count_q <= '0;
            ratio_q <= ratio_in;
            strobe  <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (evt.rise) begin
                if (last_w) begin
                    count_q <= '0;
                    ratio_q <= ratio_in;
                    strobe  <= 1'b1;
                end else begin
                    count_q <= count_q + ONE;
                end
            end
        end
    end

    // R3: strobe lasts one cycle
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R3: a strobe is always caused by a counted revolution
    a_r3_needs_edge: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(evt.rise));

    // R5: clear suppresses the strobe
    a_r5_clear_quiet: assert property (@(posedge clk) disable iff (rst)
        evt.clear |=> !strobe);

    // R6: the latched ratio only moves at clear or reload
    a_r6_ratio_held: assert property (@(posedge clk) disable iff (rst)
        (!evt.clear && !(evt.rise && last_w)) |=> $stable(ratio_q));

    // R2: the count stays below the active ratio
    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        count_q < ratio_q);

endmodule

// File: rtl/wheel_dist_div.sv
module wheel_dist_div #(
    parameter int SEL_W      = wheel_div_pkg::DEF_SEL_W,
    parameter int BASE_RATIO = wheel_div_pkg::DEF_BASE_RATIO,
    parameter int RATIO_STEP = wheel_div_pkg::DEF_RATIO_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wheel_in,
    input  logic [SEL_W-1:0] size_sel,
    output logic             dist_pulse
);
    localparam int CNT_W = $clog2(BASE_RATIO + 1);

    logic                     rise_w;
    logic [CNT_W-1:0]         ratio_w;
    wheel_div_pkg::div_evt_t  evt_w;

    wdiv_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_in (wheel_in),
        .rise_out (rise_w)
    );

    wdiv_ratio #(
        .SEL_W      (SEL_W),
        .BASE_RATIO (BASE_RATIO),
        .RATIO_STEP (RATIO_STEP),
        .CNT_W      (CNT_W)
    ) u_ratio (
        .sel   (size_sel),
        .ratio (ratio_w)
    );

    assign evt_w.rise  = rise_w;
    assign evt_w.clear = clr;

    wdiv_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_w),
        .ratio_in (ratio_w),
        .strobe   (dist_pulse)
    );

    // R1: output quiet in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !dist_pulse);

    // R7: clear together with an edge never strobes
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (clr && wheel_in) |=> !dist_pulse);

endmodule

// File: tb/sim_wheel_dist_div.sv
module sim_wheel_dist_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       wheel_in = 1'b0;
    logic [1:0] size_sel = 2'd0;
    logic       dist_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wheel_dist_div u0 (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .wheel_in   (wheel_in),
        .size_sel   (size_sel),
        .dist_pulse (dist_pulse)
    );

    function automatic int ratio_of(input int code);
        return 61 - 2 * code;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dist_pulse=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One revolution: high for hold cycles, then low for one cycle
    task automatic rev(input int hold, input logic exp, input string req);
        @(negedge clk) wheel_in = 1'b1;
        @(negedge clk) check(dist_pulse, exp, req);
        for (int h = 1; h < hold; h++) begin
            @(negedge clk) check(dist_pulse, 1'b0, req);
        end
        wheel_in = 1'b0;
        @(negedge clk) check(dist_pulse, 1'b0, req);
    endtask

    task automatic do_clear();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk) check(dist_pulse, 1'b0, "R1 reset");

        // R1/R2/R3: sweep every size code over three divisions
        for (int code = 0; code < 4; code++) begin
            size_sel = 2'(code);
            do_clear();
            for (int r = 1; r <= 3 * ratio_of(code); r++)
                rev(1, (r % ratio_of(code)) == 0, "R2/R3 ratio sweep");
        end

        // R4: a held level counts once
        size_sel = 2'd3;
        do_clear();
        for (int r = 1; r < 55; r++) rev(1, 1'b0, "R4 before held");
        rev(12, 1'b1, "R4 held level strobes once");
        for (int r = 1; r < 55; r++) rev(3, 1'b0, "R4 wide pulses");
        rev(3, 1'b1, "R4 wide pulse terminal");

        // R5: held clear blocks counting
        do_clear();
        for (int r = 1; r <= 30; r++) rev(1, 1'b0, "R5 partial");
        @(negedge clk) clr = 1'b1;
        for (int r = 1; r <= 60; r++) rev(1, 1'b0, "R5 during clear");
        clr = 1'b0;
        for (int r = 1; r <= 55; r++) rev(1, r == 55, "R5 after clear");

        // R6: select change mid-division waits for reload
        size_sel = 2'd0;
        do_clear();
        for (int r = 1; r <= 10; r++) rev(1, 1'b0, "R6 old ratio");
        size_sel = 2'd3;
        for (int r = 11; r <= 61; r++) rev(1, r == 61, "R6 old ratio finishes");
        for (int r = 1; r <= 55; r++) rev(1, r == 55, "R6 new ratio after reload");
        // R6: change applied at once by a clear
        size_sel = 2'd1;
        do_clear();
        for (int r = 1; r <= 59; r++) rev(1, r == 59, "R6 ratio via clear");

        // R7: clear coinciding with the terminal edge
        size_sel = 2'd3;
        do_clear();
        for (int r = 1; r < 55; r++) rev(1, 1'b0, "R7 approach");
        @(negedge clk) begin wheel_in = 1'b1; clr = 1'b1; end
        @(negedge clk) check(dist_pulse, 1'b0, "R7 clear wins");
        clr = 1'b0;
        wheel_in = 1'b0;
        @(negedge clk) check(dist_pulse, 1'b0, "R7 clear wins");
        for (int r = 1; r <= 55; r++) rev(1, r == 55, "R7 restart from zero");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule